// File: doc/BRIEF.md
# Fast-to-Slow Bus Cycle Bridge

This bridge lets a fast processor with a constant, free-running clock reach a slower 16-bit legacy bus whose clock is unrelated to it. The processor's own cycle is three clocks long. The bridge therefore shapes a strobe on the slow side that looks like a legacy four-state cycle. It holds that strobe back by one slow-clock period after a four-period boundary, so that every slow access both starts and finishes on that boundary.

The slow bus's transfer acknowledge and the slow clock are brought into the fast domain through two-flop synchronizers. The processor is then answered with a 16-bit port size acknowledge. Accesses that fall in the local 32-bit ROM window never reach the slow bus: the bridge answers them itself with a 32-bit size acknowledge after a short fixed wait. When a bus-mastering coprocessor holds the slow bus, or the access targets that coprocessor's register window, the processor's acknowledge is held back by one extra slow-clock period.

Top module: `bus_bridge`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, `bus_as_n` is 1 and `cpu_dsack_n` is 2'b11. Here bit 1 is the 16-bit size line and bit 0 is the 32-bit size line, both active low.
- R2: An access whose address matches the ROM window (`(addr & ROM_MASK) == ROM_BASE`, by default 0xE00000 to 0xE3FFFF) is answered with `cpu_dsack_n` = 2'b00 within five fast clocks. During the whole access `bus_as_n` stays 1.
- R3: For a slow-bus access, `bus_as_n` falls only on a slow-clock rising edge whose count since reset, taken modulo 4, is 1. That is one slow period after a four-period boundary.
- R4: For a slow-bus access, `cpu_dsack_n` stays 2'b11 until `bus_dtack_n` has been low for at least one fast clock. Without an extra wait, it becomes 2'b01 within four fast clocks after `bus_dtack_n` falls.
- R5: A processor acknowledge stays asserted until `cpu_as_n` returns high, and is withdrawn (2'b11) on the next fast clock.
- R6: `bus_as_n` stays low while the processor still holds `cpu_as_n` low after its acknowledge. It rises only after `cpu_as_n` has negated, on a slow-clock rising edge whose count modulo 4 is 0.
- R7: When `copro_hold` is high during a slow access, the 16-bit acknowledge is delayed until one further slow-clock rising edge after the synchronized `bus_dtack_n` low is seen.
- R8: An access whose address lies in 0xFF8A00 through 0xFF8A3D inclusive gets the same extra wait as R7. The address 0xFF8A3E does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processor clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| cpu_as_n | input | 1 | Processor address strobe, active low |
| cpu_addr | input | AW | Processor address |
| cpu_dsack_n | output | 2 | Size acknowledge to processor; 01 = 16-bit port, 00 = 32-bit port |
| bus_clk | input | 1 | Slow bus clock, asynchronous to `clk` |
| bus_dtack_n | input | 1 | Slow bus transfer acknowledge, active low |
| copro_hold | input | 1 | High while the bus-mastering coprocessor holds the slow bus |
| bus_as_n | output | 1 | Address strobe driven onto the slow bus, active low |

## Verification
A phase counter that drifts from the true slow-clock edge count moves the edges of `bus_as_n` off the positions that are 1 and 0 modulo 4. The bench sees this on the very next slow access. A lost synchronizer stage, or a stale extra-wait flag, changes how many fast clocks pass between `bus_dtack_n` falling and `cpu_dsack_n` moving. So a fixed sample five clocks after the acknowledge shows the fault within that same access. A state machine stuck in an acknowledge or release state leaves `cpu_dsack_n` or `bus_as_n` asserted after `cpu_as_n` negates, which is visible one clock or one boundary later.

// File: rtl/bus_bridge.sv
module bus_bridge #(
  parameter int          AW       = 24,
  parameter logic [23:0] ROM_BASE = 24'hE00000,
  parameter logic [23:0] ROM_MASK = 24'hFC0000,
  parameter int          ROM_WAIT = 2,
  parameter logic [23:0] WIN_LO   = 24'hFF8A00,
  parameter logic [23:0] WIN_HI   = 24'hFF8A3D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_as_n,
  input  logic [AW-1:0] cpu_addr,
  output logic [1:0]    cpu_dsack_n,
  input  logic          bus_clk,
  input  logic          bus_dtack_n,
  input  logic          copro_hold,
  output logic          bus_as_n
);
  localparam int CW = (ROM_WAIT > 1) ? $clog2(ROM_WAIT) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_ROMW, S_RACK, S_ALIGN, S_DELAY, S_STRB, S_XWAIT, S_ACK, S_REL
  } st_t;

  st_t st;
  logic [2:0] clk_sy;
  logic [1:0] dtk_sy, hold_sy;
  logic [1:0] phase;
  logic [CW-1:0] wcnt;
  logic xtra;

  wire rise     = clk_sy[1] & ~clk_sy[2];
  wire boundary = rise && (phase == 2'd3);
  wire dtack_s  = dtk_sy[1];
  wire hold_s   = hold_sy[1];
  wire [23:0] a24 = 24'(cpu_addr);
  wire rom_hit  = (a24 & ROM_MASK) == ROM_BASE;
  wire win_hit  = (a24 >= WIN_LO) && (a24 <= WIN_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sy  <= '0;
      dtk_sy  <= '1;
      hold_sy <= '0;
      phase   <= '0;
    end else begin
      clk_sy  <= {clk_sy[1:0], bus_clk};
      dtk_sy  <= {dtk_sy[0], bus_dtack_n};
      hold_sy <= {hold_sy[0], copro_hold};
      if (rise) phase <= phase + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bus_as_n <= 1'b1;
      wcnt     <= '0;
      xtra     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (!cpu_as_n) begin
          wcnt <= '0;
          xtra <= win_hit | hold_s;
          st   <= rom_hit ? S_ROMW : S_ALIGN;
        end
        S_ROMW: begin
          if (wcnt == CW'(ROM_WAIT - 1)) st <= S_RACK;
          else wcnt <= wcnt + 1'b1;
        end
        S_RACK:  if (cpu_as_n) st <= S_IDLE;
        S_ALIGN: begin
          xtra <= xtra | hold_s;
          if (boundary) st <= S_DELAY;
        end
        S_DELAY: begin
          xtra <= xtra | hold_s;
          if (rise) begin
            bus_as_n <= 1'b0;
            st       <= S_STRB;
          end
        end
        S_STRB: begin
          xtra <= xtra | hold_s;
          if (!dtack_s) st <= (xtra | hold_s) ? S_XWAIT : S_ACK;
        end
        S_XWAIT: if (rise) st <= S_ACK;
        S_ACK:   if (cpu_as_n) st <= S_REL;
        S_REL: if (boundary) begin
          bus_as_n <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cpu_dsack_n = (st == S_ACK)  ? 2'b01 :
                       (st == S_RACK) ? 2'b00 : 2'b11;

  p_rom_no_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_dsack_n == 2'b00) |-> bus_as_n);

  p_strobe_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_as_n) |-> (phase == 2'd1));

  p_slow_ack_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_dsack_n == 2'b01) |-> !bus_as_n);

  p_ack_needs_as_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_dsack_n[1]) |-> !$past(cpu_as_n));

  p_release_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as_n) |-> (phase == 2'd0) && $past(cpu_as_n));

  p_no_ack_without_dtack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_dsack_n[1]) && !$fell(cpu_dsack_n[0]) |-> !$past(dtack_s));
endmodule

// File: tb/bus_bridge_tb.sv
module bus_bridge_tb;
  logic clk = 0, rst_n = 0, cpu_as_n = 1, bus_clk = 0, bus_dtack_n = 1, copro_hold = 0;
  logic [23:0] cpu_addr = '0;
  logic [1:0] cpu_dsack_n;
  logic bus_as_n;
  int tests = 0, fails = 0, scnt = 0;
  bit done = 0;

  bus_bridge u_dut (.clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .cpu_addr(cpu_addr),
    .cpu_dsack_n(cpu_dsack_n), .bus_clk(bus_clk), .bus_dtack_n(bus_dtack_n),
    .copro_hold(copro_hold), .bus_as_n(bus_as_n));

  always #10 clk = ~clk;
  always #65 bus_clk = ~bus_clk;
  always @(posedge bus_clk) if (rst_n) scnt <= scnt + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(bus_as_n == 1, "R1 bus_as_n in reset", bus_as_n, 1);
    chk(cpu_dsack_n == 2'b11, "R1 dsack in reset", cpu_dsack_n, 3);
    @(negedge bus_clk); #5;
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk(bus_as_n == 1 && cpu_dsack_n == 2'b11, "R1 after release", {bus_as_n, cpu_dsack_n}, 7);
  endtask

  task automatic t_rom(input logic [23:0] a);
    bit bus_seen = 0;
    int n = 0;
    @(negedge clk) begin cpu_addr = a; cpu_as_n = 0; end
    while (cpu_dsack_n != 2'b00 && n < 20) begin
      @(negedge clk); n++;
      if (!bus_as_n) bus_seen = 1;
    end
    chk(n <= 5 && cpu_dsack_n == 2'b00, "R2 rom 32-bit ack", n, 5);
    repeat (3) @(negedge clk) if (!bus_as_n) bus_seen = 1;
    chk(cpu_dsack_n == 2'b00, "R5 rom ack held", cpu_dsack_n, 0);
    cpu_as_n = 1;
    @(negedge clk);
    chk(cpu_dsack_n == 2'b11, "R5 rom ack withdrawn", cpu_dsack_n, 3);
    chk(!bus_seen, "R2 no slow strobe on rom", bus_seen, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_slow(input logic [23:0] a, input bit extra, input string tag);
    int n = 0;
    bit early = 0;
    @(negedge clk) begin cpu_addr = a; cpu_as_n = 0; end
    while (bus_as_n && n < 200) begin
      @(negedge clk); n++;
      if (cpu_dsack_n != 2'b11) early = 1;
    end
    chk(!bus_as_n, {tag, " R3 strobe asserted"}, bus_as_n, 0);
    chk(scnt % 4 == 1, {tag, " R3 strobe phase"}, scnt % 4, 1);
    repeat (3) @(negedge clk) if (cpu_dsack_n != 2'b11) early = 1;
    @(posedge bus_clk); #1 bus_dtack_n = 0;
    @(negedge clk);
    if (cpu_dsack_n != 2'b11) early = 1;
    chk(!early, {tag, " R4 no ack before dtack"}, early, 0);
    repeat (4) @(negedge clk);
    if (extra) chk(cpu_dsack_n == 2'b11, {tag, " R7 extra wait holds ack"}, cpu_dsack_n, 3);
    else       chk(cpu_dsack_n == 2'b01, {tag, " R4 16-bit ack timing"}, cpu_dsack_n, 1);
    n = 0;
    while (cpu_dsack_n != 2'b01 && n < 20) begin @(negedge clk); n++; end
    chk(cpu_dsack_n == 2'b01, {tag, " R4 16-bit ack seen"}, cpu_dsack_n, 1);
    repeat (12) @(negedge clk);
    chk(cpu_dsack_n == 2'b01, {tag, " R5 ack held"}, cpu_dsack_n, 1);
    chk(!bus_as_n, {tag, " R6 strobe held with cpu strobe"}, bus_as_n, 0);
    cpu_as_n = 1;
    @(negedge clk);
    chk(cpu_dsack_n == 2'b11, {tag, " R5 ack withdrawn"}, cpu_dsack_n, 3);
    n = 0;
    while (!bus_as_n && n < 100) begin @(negedge clk); n++; end
    chk(bus_as_n == 1, {tag, " R6 strobe released"}, bus_as_n, 1);
    chk(scnt % 4 == 0, {tag, " R6 release phase"}, scnt % 4, 0);
    bus_dtack_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_copro();
    copro_hold = 1;
    repeat (4) @(negedge clk);
    t_slow(24'h100000, 1, "R7 copro");
    copro_hold = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_window();
    t_slow(24'hFF8A00, 1, "R8 win low");
    t_slow(24'hFF8A3D, 1, "R8 win high");
    t_slow(24'hFF8A3E, 0, "R8 past win");
  endtask

  initial begin
    t_reset();
    t_rom(24'hE00010);
    t_rom(24'hE3FFFC);
    t_slow(24'h000400, 0, "plain");
    t_slow(24'hFA0000, 0, "plain2");
    t_copro();
    t_window();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule